// File: doc/BRIEF.md
# Crosspoint switch control memory

This block holds the on/off state of every crosspoint in an 8 x 8 switch matrix: 64 cells, one bit each. A cell is picked by a 3-bit row address and a 3-bit column address. A data bit is written into it under a level-sensitive write strobe. While the strobe is high, the picked cell is transparent and its switch bit follows the data bit. When the strobe falls, the cell keeps the last value it took. Every other cell holds its value, so any pattern of row-to-column connections can be built one cell at a time.

The block runs in a system clock domain. Strobe, data and address are registered on the rising clock edge. The addressed output bit then follows the registered data combinationally for as long as the registered strobe is high. A high level on the active-high reset input clears all cells and the input registers at once, without waiting for a clock edge. While reset is high, the strobe has no effect.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While `rst_i` is high, `sw_o` is all zero, and it becomes zero without waiting for a clock edge.
- R2: The cell addressed by column `ay_i` and row `ax_i` drives bit `ay_i*8 + ax_i` of `sw_o`. A bit value of 1 means the crosspoint is on, and 0 means it is off.
- R3: While the strobe is high, the addressed bit of `sw_o` equals the `data_i` value that was sampled on the most recent rising clock edge. One clock of latency applies.
- R4: After the strobe falls, the cell that was addressed holds the last `data_i` value that was sampled while the strobe was high. This includes writing 0 to turn a crosspoint off.
- R5: A write changes only the addressed bit of `sw_o`. All other bits keep their values.
- R6: While the strobe is low, changes on `data_i`, `ax_i` and `ay_i` leave `sw_o` unchanged.
- R7: Any number of cells can be on at the same time.
- R8: If the address changes while the strobe is high, the newly addressed cell becomes transparent. The previously addressed cell keeps the value it last held.
- R9: A reset in the middle of a write clears every cell, including the cell being written. While reset stays high, a strobe that is held high writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous active-high clear of all cells |
| strb_i | input | 1 | Level-sensitive write strobe, active high |
| data_i | input | 1 | Value written to the addressed cell |
| ax_i | input | 3 | Row address |
| ay_i | input | 3 | Column address |
| sw_o | output | 64 | Switch enables, bit y*8+x for row x and column y |

## Verification
A cell that is wrong inside the block shows up directly on its own bit of `sw_o`. There is no hidden stage between a cell and its output. A fault in the decoder or the strobe gating therefore shows one clock after the strobe is sampled high: either the wrong bit follows the data, or a second bit changes with it. A capture fault shows one clock after the strobe is sampled low: the cell that was written reverts to its old value or takes the wrong value.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int XAW   = 3;
    localparam int YAW   = 3;
    localparam int AW    = XAW + YAW;
    localparam int CELLS = 1 << AW;

    typedef struct packed {
        logic          strb;
        logic          data;
        logic [AW-1:0] idx;
    } req_t;
endpackage

// File: rtl/xpt_in_stage.sv
module xpt_in_stage
    import xpt_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           strb_i,
    input  logic           data_i,
    input  logic [XAW-1:0] ax_i,
    input  logic [YAW-1:0] ay_i,
    output req_t           req_o
);
    req_t req_d, req_q;

    always_comb begin
        req_d      = req_q;
        req_d.strb = strb_i;
        req_d.data = data_i;
        // column address in the upper bits, row address in the lower bits
        req_d.idx  = {ay_i, ax_i};
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) req_q <= '0;
        else       req_q <= req_d;
    end

    assign req_o = req_q;
endmodule

// File: rtl/xpt_addr_decode.sv
module xpt_addr_decode
    import xpt_pkg::*;
(
    input  logic [AW-1:0]    idx_i,
    input  logic             en_i,
    output logic [CELLS-1:0] wen_o
);
    for (genvar g = 0; g < CELLS; g++) begin : g_dec
        assign wen_o[g] = en_i && (idx_i == AW'(g));
    end
endmodule

// File: rtl/xpt_cell_array.sv
module xpt_cell_array
    import xpt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CELLS-1:0] wen_i,
    input  logic             data_i,
    output logic [CELLS-1:0] cell_o,
    output logic [CELLS-1:0] sw_o
);
    typedef struct packed {
        logic [CELLS-1:0] cells;
    } arr_t;

    arr_t st_d, st_q;

    // A transparent cell tracks the data on every cycle, so it keeps the last value once the strobe drops.
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < CELLS; i++) begin
            if (wen_i[i]) st_d.cells[i] = data_i;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    for (genvar g = 0; g < CELLS; g++) begin : g_out
        assign sw_o[g] = wen_i[g] ? data_i : st_q.cells[g];
    end

    assign cell_o = st_q.cells;

    // R5: at most one cell changes per clock
    a_r5_single_cell: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(st_q.cells ^ $past(st_q.cells)) <= 1);

    // R6: no enable, no change
    a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (wen_i == '0) |=> $stable(st_q.cells));
endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem
    import xpt_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             strb_i,
    input  logic             data_i,
    input  logic [XAW-1:0]   ax_i,
    input  logic [YAW-1:0]   ay_i,
    output logic [CELLS-1:0] sw_o
);
    req_t             req;
    logic [CELLS-1:0] wen;
    logic [CELLS-1:0] cells;

    xpt_in_stage i_in (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .strb_i (strb_i),
        .data_i (data_i),
        .ax_i   (ax_i),
        .ay_i   (ay_i),
        .req_o  (req)
    );

    xpt_addr_decode i_dec (
        .idx_i (req.idx),
        .en_i  (req.strb),
        .wen_o (wen)
    );

    xpt_cell_array i_arr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .wen_i  (wen),
        .data_i (req.data),
        .cell_o (cells),
        .sw_o   (sw_o)
    );

    // R1: reset forces all switches off
    a_r1_reset_clear: assert property (@(posedge clk_i)
        rst_i |-> (sw_o == '0));

    // R4: after the strobe falls, the cells hold what was visible in the last transparent cycle
    a_r4_capture: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(req.strb) |-> (cells == $past(sw_o)));
endmodule

// File: tb/test_xpt_ctrl_mem.sv
module test_xpt_ctrl_mem;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst;
    logic        strb;
    logic        data;
    logic [2:0]  ax;
    logic [2:0]  ay;
    logic [63:0] sw;
    logic [63:0] model;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 0;

    xpt_ctrl_mem i_xpt_ctrl_mem (
        .clk_i  (clk),
        .rst_i  (rst),
        .strb_i (strb),
        .data_i (data),
        .ax_i   (ax),
        .ay_i   (ay),
        .sw_o   (sw)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int cidx(int x, int y);
        return y * 8 + x;
    endfunction

    function automatic logic [63:0] with_bit(logic [63:0] v, int i, logic b);
        logic [63:0] r = v;
        r[i] = b;
        return r;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Set the address with the strobe low, hold the strobe high for 'hold' cycles with changing data, then drop it.
    task automatic do_write(int x, int y, logic d0, int hold, bit rnd);
        int i = cidx(x, y);
        ax = 3'(x); ay = 3'(y); strb = 0;
        tick();
        chk("R6 idle before strobe", sw, model);
        strb = 1; data = d0;
        tick();
        chk("R3 transparent first cycle", sw, with_bit(model, i, data));
        for (int k = 1; k < hold; k++) begin
            if (rnd) data = 1'($urandom);
            else     data = ~data;
            tick();
            chk("R3 follows data", sw, with_bit(model, i, data));
        end
        strb = 0;
        model[i] = data;
        tick();
        chk("R4 R5 captured on fall", sw, model);
        data = ~data; ax = 3'($urandom); ay = 3'($urandom);
        tick();
        chk("R6 strobe low ignores inputs", sw, model);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0808));
        rst = 1; strb = 0; data = 0; ax = 0; ay = 0; model = '0;
        tick(); tick();
        chk("R1 reset state", sw, '0);
        rst = 0;
        tick();
        chk("R1 after release", sw, '0);

        // R2 mapping against a hand value: row 3, column 5 -> bit 43
        do_write(3, 5, 1'b1, 1, 1'b0);
        chk("R2 index mapping", sw, 64'h0000_0800_0000_0000);

        // R4 turning a crosspoint off
        do_write(3, 5, 1'b0, 1, 1'b0);
        chk("R4 write zero", sw, '0);

        // R3 toggling data during a long strobe
        do_write(7, 0, 1'b1, 5, 1'b0);
        do_write(0, 7, 1'b0, 4, 1'b0);

        // R7 several cells on at once, one per column
        for (int y = 0; y < 8; y++) do_write(7 - y, y, 1'b1, 1, 1'b0);
        n_cmp++;
        if ($countones(sw) !== $countones(model) || $countones(sw) < 8) begin
            n_bad++;
            $display("FAIL R7: actual %0d on expected %0d on", $countones(sw), $countones(model));
        end

        // R8 address moves while the strobe is high
        $display("NOTE: setup violation (address change during strobe) applied on purpose");
        ax = 3'd1; ay = 3'd1; strb = 0;
        tick();
        strb = 1; data = 1;
        tick();
        chk("R8 first cell transparent", sw, with_bit(model, cidx(1, 1), 1'b1));
        model[cidx(1, 1)] = 1'b1;
        ax = 3'd2; ay = 3'd6; data = 0;
        tick();
        chk("R8 old cell kept, new follows", sw, with_bit(model, cidx(2, 6), 1'b0));
        strb = 0;
        model[cidx(2, 6)] = 1'b0;
        tick();
        chk("R8 after fall", sw, model);

        // R9 reset in the middle of a write
        ax = 3'd4; ay = 3'd4; strb = 1; data = 1;
        tick();
        chk("R9 write in progress", sw, with_bit(model, cidx(4, 4), 1'b1));
        #1 rst = 1;
        #1 chk("R1 R9 asynchronous clear", sw, '0);
        model = '0;
        tick(); tick();
        chk("R9 strobe held during reset", sw, '0);
        strb = 0;
        tick();
        rst = 0;
        tick();
        chk("R9 after release", sw, '0);

        // random sequences
        for (int n = 0; n < 300; n++) begin
            do_write(int'($urandom % 8), int'($urandom % 8), 1'($urandom),
                     1 + int'($urandom % 4), 1'b1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule